// File: doc/BRIEF.md
# Warp-Class Two-Level DRAM Request Scheduler

This block sits in front of a DRAM channel and decides which pending memory request goes out next. Each incoming request is labelled with the divergence class of the warp that issued it. That class records how often the warp's accesses hit in the cache. Requests from the two cache-friendly classes wait in an urgent queue. Requests from the other classes wait in a background queue. The background queue is served only while the urgent queue is empty, so that mostly-hitting warps are not held up by the long miss traffic of other warps.

Inside each queue, the next request is chosen by open-row-first, then age. Among the waiting requests whose row matches the row currently open in their bank, the oldest one goes first. If no waiting request matches, the oldest request in the queue goes. A small table holds one open row per bank and is updated by every issue. At most one request leaves per cycle, through a valid/ready handshake toward the DRAM controller. Requests enter through a valid/ready handshake as well, and the block refuses them while the queue they would go to is full.

Top module: `warp_class_mem_sched`

## Requirements
- R1: A request whose class code is 0 (all-hit) or 1 (mostly-hit) is placed in the urgent queue. When it is issued, `iss_urgent` is 1.
- R2: A request whose class code is 2 (balanced), 3 (mostly-miss), 4 (all-miss) or any unused code 5 to 7 is placed in the background queue. When it is issued, `iss_urgent` is 0.
- R3: While the urgent queue holds any request, `iss_valid` is 1 and the offered request comes from the urgent queue. A background request is never offered while an urgent request is waiting.
- R4: Within the queue being served, if one or more waiting requests have a row equal to the open row of their bank, the oldest of those requests is offered.
- R5: Within the queue being served, if no waiting request matches the open row of its bank, the oldest request in that queue is offered.
- R6: After reset, no bank has an open row. A handshake on the issue side (`iss_valid` and `iss_ready` both 1) makes the issued row the open row of the issued bank, starting in the next cycle.
- R7: Each queue holds `QDEPTH` requests (8 by default). `req_ready` is 0 exactly when the queue selected by the current `req_type` is full, so that a full urgent queue does not block background requests, and the other way round.
- R8: At most one request is issued per cycle. While `iss_ready` is 0, no request leaves a queue and `iss_valid` stays 1.
- R9: After reset, both queues are empty, `iss_valid` is 0 and `req_ready` is 1.
- R10: A request can be accepted in the same cycle that another request is issued. The accepted request becomes the youngest entry of its queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Incoming request present |
| req_ready | output | 1 | The queue selected by `req_type` can take the request |
| req_type | input | 3 | Warp divergence class code (0 all-hit … 4 all-miss) |
| req_bank | input | $clog2(NUM_BANKS) | Target DRAM bank |
| req_row | input | ROW_W | Target row |
| req_tag | input | TAG_W | Requester tag, returned unchanged on issue |
| iss_valid | output | 1 | A request is offered to DRAM |
| iss_ready | input | 1 | DRAM takes the offered request |
| iss_bank | output | $clog2(NUM_BANKS) | Bank of the offered request |
| iss_row | output | ROW_W | Row of the offered request |
| iss_tag | output | TAG_W | Tag of the offered request |
| iss_urgent | output | 1 | Offered request comes from the urgent queue |

## Verification
First, single requests of each class code go into an idle block, which shows whether the steering sends every code to the correct queue. Next, the urgent queue is filled while the background queue keeps accepting requests, which separates per-queue back-pressure from a shared full flag. Then bursts mixing same-row and other-row requests to one bank are drained. These show whether a younger row hit overtakes an older miss, whether requests with equal hit status keep their arrival order, and whether a freshly opened row changes the choice in the next cycle. Finally, a long random run with few rows, a stalling DRAM side and requests arriving while others are issued is checked every cycle against a model built from queues. This catches starvation and ordering faults that the directed cases miss.

// File: rtl/wps_pkg.sv
package wps_pkg;

  localparam int CLASS_W = 3;

  typedef enum logic [CLASS_W-1:0] {
    WC_ALL_HIT     = 3'd0,
    WC_MOSTLY_HIT  = 3'd1,
    WC_BALANCED    = 3'd2,
    WC_MOSTLY_MISS = 3'd3,
    WC_ALL_MISS    = 3'd4
  } warp_class_e;

  // Cache-friendly classes are steered to the urgent queue.
  function automatic logic class_is_urgent(input logic [CLASS_W-1:0] code);
    return (code == WC_ALL_HIT) || (code == WC_MOSTLY_HIT);
  endfunction

endpackage

// File: rtl/wps_open_rows.sv
module wps_open_rows #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 10,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic [BANK_W-1:0] upd_bank,
  input  logic [ROW_W-1:0]  upd_row,
  output logic [ROW_W-1:0]  open_row [NUM_BANKS],
  output logic [NUM_BANKS-1:0] open_vld
);

  for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
    logic hit_this;
    assign hit_this = upd && (upd_bank == BANK_W'(gb));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        open_vld[gb] <= 1'b0;
        open_row[gb] <= '0;
      end else if (hit_this) begin
        open_vld[gb] <= 1'b1;
        open_row[gb] <= upd_row;
      end
    end
  end

endmodule

// File: rtl/wps_queue.sv
module wps_queue #(
  parameter int DEPTH     = 8,
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 10,
  parameter int TAG_W     = 8,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enq,
  input  logic [BANK_W-1:0] enq_bank,
  input  logic [ROW_W-1:0]  enq_row,
  input  logic [TAG_W-1:0]  enq_tag,
  input  logic              deq,
  input  logic [ROW_W-1:0]  open_row [NUM_BANKS],
  input  logic [NUM_BANKS-1:0] open_vld,
  output logic              full,
  output logic              empty,
  output logic [CNT_W-1:0]  count,
  output logic [BANK_W-1:0] head_bank,
  output logic [ROW_W-1:0]  head_row,
  output logic [TAG_W-1:0]  head_tag
);

  typedef struct packed {
    logic [BANK_W-1:0] bank;
    logic [ROW_W-1:0]  row;
    logic [TAG_W-1:0]  tag;
  } ent_t;

  // Entry 0 is always the oldest; entries are kept compacted by age.
  ent_t             ent     [DEPTH];
  ent_t             ent_nxt [DEPTH];
  ent_t             shifted [DEPTH];
  logic [DEPTH-1:0] row_hit;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] wr_slot;
  logic [IDX_W-1:0] sel_idx;
  logic [IDX_W-1:0] first_hit;
  logic             any_hit;
  ent_t             enq_ent;

  // Lowest set index of a vector: the oldest qualifying entry.
  function automatic logic [IDX_W-1:0] oldest_of(input logic [DEPTH-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  assign enq_ent   = '{bank: enq_bank, row: enq_row, tag: enq_tag};
  assign any_hit   = |row_hit;
  assign first_hit = oldest_of(row_hit);
  assign sel_idx   = any_hit ? first_hit : '0;
  assign wr_slot   = cnt_q - CNT_W'(deq);

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
    logic live;
    assign live = CNT_W'(gi) < cnt_q;
    assign row_hit[gi] = live && open_vld[ent[gi].bank] &&
                         (open_row[ent[gi].bank] == ent[gi].row);

    if (gi < DEPTH - 1) begin : g_shift
      assign shifted[gi] = ent[gi+1];
    end else begin : g_last
      assign shifted[gi] = ent[gi];
    end

    always_comb begin
      ent_nxt[gi] = ent[gi];
      if (deq && (IDX_W'(gi) >= sel_idx)) ent_nxt[gi] = shifted[gi];
      if (enq && (CNT_W'(gi) == wr_slot)) ent_nxt[gi] = enq_ent;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) ent[gi] <= '0;
      else        ent[gi] <= ent_nxt[gi];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + CNT_W'(enq) - CNT_W'(deq);
  end

  assign count     = cnt_q;
  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign empty     = (cnt_q == '0);
  assign head_bank = ent[sel_idx].bank;
  assign head_row  = ent[sel_idx].row;
  assign head_tag  = ent[sel_idx].tag;

endmodule

// File: rtl/warp_class_mem_sched.sv
module warp_class_mem_sched #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 10,
  parameter int TAG_W     = 8,
  parameter int QDEPTH    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [wps_pkg::CLASS_W-1:0]  req_type,
  input  logic [$clog2(NUM_BANKS)-1:0] req_bank,
  input  logic [ROW_W-1:0]             req_row,
  input  logic [TAG_W-1:0]             req_tag,
  output logic                         iss_valid,
  input  logic                         iss_ready,
  output logic [$clog2(NUM_BANKS)-1:0] iss_bank,
  output logic [ROW_W-1:0]             iss_row,
  output logic [TAG_W-1:0]             iss_tag,
  output logic                         iss_urgent
);

  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int CNT_W  = $clog2(QDEPTH + 1);

  logic              to_urgent;
  logic              accept;
  logic              fire;
  logic              u_enq, b_enq, u_deq, b_deq;
  logic              u_full, u_empty, b_full, b_empty;
  logic [CNT_W-1:0]  u_count, b_count;
  logic [BANK_W-1:0] u_bank, b_bank;
  logic [ROW_W-1:0]  u_row, b_row;
  logic [TAG_W-1:0]  u_tag, b_tag;
  logic [ROW_W-1:0]  orow [NUM_BANKS];
  logic [NUM_BANKS-1:0] ovld;

  // Enqueue steering by divergence class.
  assign to_urgent = wps_pkg::class_is_urgent(req_type);
  assign req_ready = to_urgent ? !u_full : !b_full;
  assign accept    = req_valid && req_ready;
  assign u_enq     = accept && to_urgent;
  assign b_enq     = accept && !to_urgent;

  // Strict priority between the classes.
  assign iss_urgent = !u_empty;
  assign iss_valid  = !u_empty || !b_empty;
  assign iss_bank   = iss_urgent ? u_bank : b_bank;
  assign iss_row    = iss_urgent ? u_row  : b_row;
  assign iss_tag    = iss_urgent ? u_tag  : b_tag;
  assign fire       = iss_valid && iss_ready;
  assign u_deq      = fire && iss_urgent;
  assign b_deq      = fire && !iss_urgent;

  wps_queue #(
    .DEPTH(QDEPTH), .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .TAG_W(TAG_W)
  ) u_urgent_q (
    .clk(clk), .rst_n(rst_n),
    .enq(u_enq), .enq_bank(req_bank), .enq_row(req_row), .enq_tag(req_tag),
    .deq(u_deq), .open_row(orow), .open_vld(ovld),
    .full(u_full), .empty(u_empty), .count(u_count),
    .head_bank(u_bank), .head_row(u_row), .head_tag(u_tag)
  );

  wps_queue #(
    .DEPTH(QDEPTH), .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .TAG_W(TAG_W)
  ) u_backgr_q (
    .clk(clk), .rst_n(rst_n),
    .enq(b_enq), .enq_bank(req_bank), .enq_row(req_row), .enq_tag(req_tag),
    .deq(b_deq), .open_row(orow), .open_vld(ovld),
    .full(b_full), .empty(b_empty), .count(b_count),
    .head_bank(b_bank), .head_row(b_row), .head_tag(b_tag)
  );

  wps_open_rows #(
    .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)
  ) u_open_rows (
    .clk(clk), .rst_n(rst_n),
    .upd(fire), .upd_bank(iss_bank), .upd_row(iss_row),
    .open_row(orow), .open_vld(ovld)
  );

endmodule

// File: rtl/wps_sched_chk.sv
module wps_sched_chk #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 10,
  parameter int QDEPTH    = 8,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int CNT_W    = $clog2(QDEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [2:0]        req_type,
  input logic              iss_valid,
  input logic              iss_ready,
  input logic              iss_urgent,
  input logic [BANK_W-1:0] iss_bank,
  input logic [ROW_W-1:0]  iss_row,
  input logic              u_empty,
  input logic [CNT_W-1:0]  u_count,
  input logic [CNT_W-1:0]  b_count,
  input logic              u_enq,
  input logic              u_deq,
  input logic [ROW_W-1:0]  open_row [NUM_BANKS],
  input logic [NUM_BANKS-1:0] open_vld
);

  // R3: background traffic only while the urgent queue is empty
  p_bg_waits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_urgent) |-> u_empty);

  // R3: a waiting urgent request is always offered
  p_urgent_offered_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !u_empty |-> (iss_valid && iss_urgent));

  // R6: issued row becomes the bank's open row
  p_open_row_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready) |=>
      (open_vld[$past(iss_bank)] && open_row[$past(iss_bank)] == $past(iss_row)));

  // R7: a full urgent queue refuses urgent-class requests
  p_full_refuse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_type <= 3'd1 && u_count == CNT_W'(QDEPTH)) |-> !req_ready);

  // R7: occupancy never exceeds the depth
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (u_count <= CNT_W'(QDEPTH)) && (b_count <= CNT_W'(QDEPTH)));

  // R8: a stalled offer does not vanish
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready) |=> iss_valid);

  // R10: simultaneous accept and issue leaves occupancy unchanged
  p_swap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (u_enq && u_deq) |=> (u_count == $past(u_count)));

endmodule

bind warp_class_mem_sched wps_sched_chk #(
  .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .QDEPTH(QDEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_ready(req_ready), .req_type(req_type),
  .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_urgent(iss_urgent),
  .iss_bank(iss_bank), .iss_row(iss_row),
  .u_empty(u_empty), .u_count(u_count), .b_count(b_count),
  .u_enq(u_enq), .u_deq(u_deq),
  .open_row(orow), .open_vld(ovld)
);

// File: tb/warp_class_mem_sched_bench.sv
module warp_class_mem_sched_bench;

  localparam int NB    = 4;
  localparam int ROW_W = 10;
  localparam int TAG_W = 8;
  localparam int DEP   = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [2:0]       req_type = '0;
  logic [1:0]       req_bank = '0;
  logic [ROW_W-1:0] req_row = '0;
  logic [TAG_W-1:0] req_tag = '0;
  logic             iss_valid;
  logic             iss_ready = 1'b0;
  logic [1:0]       iss_bank;
  logic [ROW_W-1:0] iss_row;
  logic [TAG_W-1:0] iss_tag;
  logic             iss_urgent;

  always #2 clk = ~clk;

  warp_class_mem_sched #(.NUM_BANKS(NB), .ROW_W(ROW_W), .TAG_W(TAG_W), .QDEPTH(DEP))
  u_warp_class_mem_sched (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_type(req_type),
    .req_bank(req_bank), .req_row(req_row), .req_tag(req_tag),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_bank(iss_bank),
    .iss_row(iss_row), .iss_tag(iss_tag), .iss_urgent(iss_urgent)
  );

  typedef struct { int bank; int row; int tag; } mreq_t;
  mreq_t uq[$];
  mreq_t bq[$];
  int    orow [NB];
  bit    ovld [NB];
  int    total = 0;
  int    bad = 0;
  int    tagc = 0;
  bit    done = 0;
  string scen = "reset";

  task automatic chk(bit ok, string lbl, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s [%s] actual=%0d expected=%0d", lbl, scen, act, exp);
    end
  endtask

  // Model pick: oldest open-row match, else oldest.
  function automatic int mpick(mreq_t q[$], output bit hit);
    hit = 0;
    foreach (q[i]) begin
      if (ovld[q[i].bank] && orow[q[i].bank] == q[i].row) begin
        hit = 1;
        return i;
      end
    end
    return 0;
  endfunction

  task automatic step(bit v, int ty, int bk, int rw, bit rdy);
    bit    exp_v, use_u, hit, exp_rdy;
    int    idx;
    mreq_t e;
    @(negedge clk);
    exp_v = (uq.size() > 0) || (bq.size() > 0);
    use_u = uq.size() > 0;
    chk(iss_valid == exp_v, "R8 valid", int'(iss_valid), int'(exp_v));
    if (exp_v) begin
      idx = use_u ? mpick(uq, hit) : mpick(bq, hit);
      e   = use_u ? uq[idx] : bq[idx];
      chk(iss_urgent == use_u, "R3 class", int'(iss_urgent), int'(use_u));
      chk(int'(iss_tag) == e.tag, hit ? "R4 R6 hit tag" : "R5 oldest tag", int'(iss_tag), e.tag);
      chk(int'(iss_bank) == e.bank && int'(iss_row) == e.row, "R4 R5 bank/row",
          int'(iss_row), e.row);
    end
    req_valid = v;
    req_type  = 3'(ty);
    req_bank  = 2'(bk);
    req_row   = ROW_W'(rw);
    req_tag   = TAG_W'(tagc);
    iss_ready = rdy;
    #1;
    exp_rdy = (ty <= 1) ? (uq.size() < DEP) : (bq.size() < DEP);
    chk(req_ready == exp_rdy, "R7 ready", int'(req_ready), int'(exp_rdy));
    if (exp_v && rdy) begin
      if (use_u) uq.delete(idx); else bq.delete(idx);
      orow[e.bank] = e.row;
      ovld[e.bank] = 1;
    end
    if (v && exp_rdy) begin
      e = '{bank: bk, row: rw, tag: tagc % 256};
      if (ty <= 1) uq.push_back(e); else bq.push_back(e);
      tagc++;
    end
  endtask

  task automatic look();
    @(posedge clk);
    #1;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    foreach (ovld[i]) begin ovld[i] = 0; orow[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    look();
    // R9: empty after reset, accepting
    scen = "R9 reset";
    chk(iss_valid == 1'b0, "R9 iss_valid", int'(iss_valid), 0);
    chk(req_ready == 1'b1, "R9 req_ready", int'(req_ready), 1);

    // R2: background codes, including unused ones
    scen = "R2 steering";
    step(1, 3, 0, 5, 0);
    look();
    chk(iss_valid && !iss_urgent, "R2 code3 to background", int'(iss_urgent), 0);
    step(1, 6, 1, 2, 0);
    step(1, 2, 2, 9, 0);
    step(1, 4, 3, 1, 0);
    // R1: urgent codes overtake background
    scen = "R1 steering";
    step(1, 1, 1, 7, 0);
    look();
    chk(iss_valid && iss_urgent, "R1 code1 to urgent", int'(iss_urgent), 1);
    step(1, 0, 2, 3, 0);
    // R8: stall keeps everything
    scen = "R8 stall";
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0);
    // R3: drain, urgent first
    scen = "R3 drain";
    for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 1);

    // R7: fill urgent queue, background still accepted
    scen = "R7 fill";
    for (int i = 0; i < DEP + 1; i++) step(1, i % 2, i % NB, i, 0);
    step(1, 1, 0, 0, 0);
    look();
    chk(req_ready == 1'b0, "R7 urgent full refuses", int'(req_ready), 0);
    step(1, 4, 1, 1, 0);
    look();
    chk(req_ready == 1'b1, "R7 background still open", int'(req_ready), 1);
    for (int i = 0; i < 12; i++) step(0, 0, 0, 0, 1);

    // R4 R5 R6: hit overtaking and age among equals on one bank
    scen = "R4 R5 R6 row order";
    step(1, 0, 0, 11, 1);
    step(0, 0, 0, 0, 0);
    step(1, 0, 0, 20, 0);
    step(1, 0, 0, 11, 0);
    step(1, 0, 0, 21, 0);
    step(1, 0, 0, 11, 0);
    step(1, 1, 1, 20, 0);
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 1);

    // R10: accept while issuing
    scen = "R10 accept during issue";
    step(1, 2, 0, 4, 0);
    step(1, 2, 1, 4, 0);
    for (int i = 0; i < 6; i++) step(1, 2 + i % 3, i % NB, 4, 1);
    for (int i = 0; i < 10; i++) step(0, 0, 0, 0, 1);

    // Random mix across all requirements
    scen = "R1 R2 R3 R4 R5 R6 R7 R8 R10 random";
    for (int i = 0; i < 4000; i++)
      step(($urandom % 4) != 0, $urandom % 8, $urandom % NB, $urandom % 3,
           ($urandom % 3) != 0);
    for (int i = 0; i < 40; i++) step(0, 0, 0, 0, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule